// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block gathers level-sensitive interrupt lines from on-chip peripherals and folds them into one request line for the host processor. Software reaches it through a small register window with five word addresses: a configuration word holding a global enable, a per-source mask, an in-service word that is cleared by writing ones, a read-only view of the raw source levels, and a 16-bit vector word.

To take an interrupt, the host writes 1 to bit 0 of the vector word. It then reads the same word and finds a 5-bit vector in bits 15 to 11. Source i reports vector i+1, and when several sources qualify the highest index wins. Vector 0 is kept for the error case. That case arises when a write that clears a mask bit lands in the same cycle as the matching source rises. The controller then latches an error condition and does not lose the event silently. The host clears that condition only by acknowledging it.

Top module: `vpic_top`

## Requirements
- R1: After reset, reads of the configuration, mask, in-service and vector words return 0 and `irq_o` is low.
- R2: The mask word (address 1, bit i for source i) reads back what was written, and a source whose mask bit is 0 never drives `irq_o`.
- R3: `irq_o` stays low while bit 0 of the configuration word (address 0) is 0, whatever the sources do.
- R4: Address 3 reads the present source levels. A source that is unmasked and not in service keeps `irq_o` high for as long as its input stays high.
- R5: Writing the vector word (address 4) with bit 0 set latches a vector. A later read returns it in bits 15:11 with all other bits 0. The vector is i+1 for the highest-indexed source i that is high, unmasked and not in service.
- R6: An acknowledge that returns a source vector sets that source's bit in the in-service word (address 2). While that bit is set, the source neither drives `irq_o` nor wins a later acknowledge.
- R7: Writing the in-service word clears exactly the bits written as 1 and leaves the other bits unchanged.
- R8: A mask write that clears bit i in the same cycle that source i rises sets an error condition. The error condition drives `irq_o` when the controller is enabled. It takes precedence at the next acknowledge, which returns vector 0 and clears it.
- R9: An acknowledge with no error condition and no qualifying source returns vector 0 and leaves the in-service word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Level-sensitive interrupt sources |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Combined interrupt request to the host |

## Verification
The assertions assume that only one register access happens per cycle, so a mask write, an in-service clear and an acknowledge never share a cycle. They also assume that reset is released with no register write pending. The random phase of the stimulus changes the source levels only in cycles without a mask write, so no race arises there. Races are produced only by a directed sequence whose outcome is known in advance. Every access goes through the single write strobe and one address.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 3;
    localparam int VEC_W  = 5;
    localparam int VEC_LSB = 11;

    typedef enum logic [ADDR_W-1:0] {
        A_CFG   = 3'd0,
        A_MASK  = 3'd1,
        A_INSVC = 3'd2,
        A_PEND  = 3'd3,
        A_VEC   = 3'd4
    } reg_addr_e;

    localparam logic [VEC_W-1:0] ERR_VEC = '0;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] idx;
    } grant_t;

    function automatic logic [REG_W-1:0] vec_word(input logic [VEC_W-1:0] v);
        logic [REG_W-1:0] w;
        w = '0;
        w[VEC_LSB +: VEC_W] = v;
        return w;
    endfunction

endpackage

// File: rtl/vpic_prio_enc.sv
module vpic_prio_enc
    import vpic_pkg::*;
#(
    parameter int N = 31
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] elig_i,
    output grant_t       grant_o
);

    logic [N:0]   above;
    logic [N-1:0] hit;

    assign above[N] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_chain
            assign above[i] = above[i+1] | elig_i[i];
            assign hit[i]   = elig_i[i] & ~above[i+1];
        end
    endgenerate

    always_comb begin
        grant_o.vld = above[0];
        grant_o.idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) grant_o.idx = grant_o.idx | VEC_W'(i);
        end
    end

    AST_GRANT_HIGHEST: assert property (@(posedge clk) disable iff (rst)
        grant_o.vld |-> ((elig_i >> grant_o.idx) == N'(1))) else $error("grant not highest"); // R5

endmodule

// File: rtl/vpic_race_det.sv
module vpic_race_det #(
    parameter int N = 31
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] mask_q_i,
    input  logic         mask_wr_i,
    input  logic [N-1:0] mask_new_i,
    input  logic         err_clr_i,
    output logic         err_o
);

    logic [N-1:0] src_q;
    logic         race;

    assign race = mask_wr_i & (|(mask_q_i & ~mask_new_i & src_i & ~src_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            err_o <= 1'b0;
        end else begin
            src_q <= src_i;
            if (race)           err_o <= 1'b1;
            else if (err_clr_i) err_o <= 1'b0;
        end
    end

    AST_RACE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        race |=> err_o) else $error("race not flagged"); // R8

endmodule

// File: rtl/vpic_regfile.sv
module vpic_regfile
    import vpic_pkg::*;
#(
    parameter int N = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             set_vld_i,
    input  logic [VEC_W-1:0] set_idx_i,
    output logic             en_o,
    output logic [N-1:0]     mask_o,
    output logic [N-1:0]     insvc_o
);

    logic wr_cfg, wr_mask, wr_ins;

    assign wr_cfg  = wr_en_i && (addr_i == A_CFG);
    assign wr_mask = wr_en_i && (addr_i == A_MASK);
    assign wr_ins  = wr_en_i && (addr_i == A_INSVC);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_o    <= 1'b0;
            mask_o  <= '0;
            insvc_o <= '0;
        end else begin
            if (wr_cfg)  en_o   <= wdata_i[0];
            if (wr_mask) mask_o <= wdata_i[N-1:0];
            if (wr_ins)
                insvc_o <= insvc_o & ~wdata_i[N-1:0];
            else if (set_vld_i)
                insvc_o <= insvc_o | (N'(1) << set_idx_i);
        end
    end

    AST_RESET_MASK: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mask_o == '0 && !en_o)) else $error("reset state"); // R1
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        wr_ins |=> ((insvc_o & $past(wdata_i[N-1:0])) == '0)) else $error("w1c clear"); // R7
    AST_W1C_KEEPS: assert property (@(posedge clk) disable iff (rst)
        wr_ins |=> ((insvc_o & ~$past(wdata_i[N-1:0])) ==
                    ($past(insvc_o) & ~$past(wdata_i[N-1:0])))) else $error("w1c keep"); // R7

endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter int NSRC = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic              irq_o
);

    logic             en;
    logic [NSRC-1:0]  mask, insvc, elig;
    logic             err;
    logic             ack;
    logic             set_vld;
    grant_t           grant;
    logic [VEC_W-1:0] vec_q;

    assign ack     = wr_en_i && (addr_i == A_VEC) && wdata_i[0];
    assign elig    = src_i & mask & ~insvc;
    assign set_vld = ack && !err && grant.vld;

    vpic_regfile #(.N(NSRC)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .set_vld_i(set_vld), .set_idx_i(grant.idx),
        .en_o(en), .mask_o(mask), .insvc_o(insvc)
    );

    vpic_prio_enc #(.N(NSRC)) u_prio (
        .clk(clk), .rst(rst), .elig_i(elig), .grant_o(grant)
    );

    vpic_race_det #(.N(NSRC)) u_race (
        .clk(clk), .rst(rst), .src_i(src_i), .mask_q_i(mask),
        .mask_wr_i(wr_en_i && (addr_i == A_MASK)),
        .mask_new_i(wdata_i[NSRC-1:0]),
        .err_clr_i(ack), .err_o(err)
    );

    always_ff @(posedge clk) begin
        if (rst)
            vec_q <= ERR_VEC;
        else if (ack) begin
            if (err)            vec_q <= ERR_VEC;
            else if (grant.vld) vec_q <= grant.idx + VEC_W'(1);
            else                vec_q <= ERR_VEC;
        end
    end

    assign irq_o = en & ((|elig) | err);

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            A_CFG:   rdata_o[0] = en;
            A_MASK:  rdata_o[NSRC-1:0] = mask;
            A_INSVC: rdata_o[NSRC-1:0] = insvc;
            A_PEND:  rdata_o[NSRC-1:0] = src_i;
            A_VEC:   rdata_o = vec_word(vec_q);
            default: rdata_o = '0;
        endcase
    end

    AST_ACK_SETS_INSVC: assert property (@(posedge clk) disable iff (rst)
        set_vld |=> ((insvc & ~$past(insvc)) != '0)) else $error("insvc not set"); // R6
    AST_ERR_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack && err) |=> (!err && vec_q == ERR_VEC && $stable(insvc))) else $error("err ack"); // R8
    AST_EMPTY_ACK: assert property (@(posedge clk) disable iff (rst)
        (ack && !err && !grant.vld) |=> (vec_q == ERR_VEC && $stable(insvc))) else $error("empty ack"); // R9

endmodule

// File: tb/tb_vpic_top.sv
`timescale 1ns/1ps
module tb_vpic_top;
    localparam int NSRC = 31;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [NSRC-1:0] src = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    logic [NSRC-1:0] m_mask, m_ins;

    vpic_top #(.NSRC(NSRC)) dut (
        .clk(clk), .rst(rst), .src_i(src), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic set_src(input logic [NSRC-1:0] v);
        @(negedge clk);
        src = v;
        #1;
    endtask

    function automatic logic [31:0] vw(input int v);
        return 32'(v) << 11;
    endfunction

    function automatic int best(input logic [NSRC-1:0] e);
        for (int i = NSRC - 1; i >= 0; i--) if (e[i]) return i + 1;
        return 0;
    endfunction

    task automatic ack_chk(input string tag, input int exp_vec);
        logic [31:0] d;
        wr(3'd4, 32'h1);
        rd(3'd4, d);
        chk(tag, d, vw(exp_vec));
    endtask

    initial begin
        #(4ns * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        rd(3'd0, d); chk("R1 cfg", d, 0);
        rd(3'd1, d); chk("R1 mask", d, 0);
        rd(3'd2, d); chk("R1 insvc", d, 0);
        rd(3'd4, d); chk("R1 vec", d, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R2 / R3 / R4 gating
        wr(3'd0, 32'h1);
        set_src(NSRC'(1) << 5);
        chk("R2 masked source no irq", {31'b0, irq}, 0);
        rd(3'd3, d); chk("R4 pending view", d, 32'h20);
        wr(3'd1, 32'h0000_0220);
        rd(3'd1, d); chk("R2 mask readback", d, 32'h220);
        chk("R2 unmasked irq", {31'b0, irq}, 1);
        wr(3'd0, 32'h0);
        chk("R3 disabled no irq", {31'b0, irq}, 0);
        wr(3'd0, 32'h1);
        repeat (3) @(negedge clk);
        #1 chk("R4 level held irq", {31'b0, irq}, 1);

        // R5 / R6 / R9
        set_src((NSRC'(1) << 5) | (NSRC'(1) << 9));
        ack_chk("R5 highest wins", 10);
        rd(3'd2, d); chk("R6 insvc set", d, 32'h200);
        chk("R6 irq from other source", {31'b0, irq}, 1);
        ack_chk("R6 in-service skipped", 6);
        chk("R6 all in service irq low", {31'b0, irq}, 0);
        ack_chk("R9 empty ack vector", 0);
        rd(3'd2, d); chk("R9 insvc unchanged", d, 32'h220);

        // R7
        wr(3'd2, 32'h0000_0200);
        rd(3'd2, d); chk("R7 w1c selective", d, 32'h20);
        chk("R4 re-presented while held", {31'b0, irq}, 1);
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, d); chk("R7 w1c all", d, 0);

        // R8 race
        set_src(NSRC'(1) << 7);
        wr(3'd1, 32'h0000_0088);
        @(negedge clk);
        src = (NSRC'(1) << 7) | (NSRC'(1) << 3);
        wr_en = 1'b1; addr = 3'd1; wdata = 32'h0000_0080;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        wr(3'd1, 32'h0);
        #1 chk("R8 error drives irq", {31'b0, irq}, 1);
        wr(3'd1, 32'h0000_0080);
        ack_chk("R8 error vector first", 0);
        rd(3'd2, d); chk("R8 no insvc on error", d, 0);
        ack_chk("R8 source after error", 8);
        wr(3'd2, 32'hFFFF_FFFF);

        // random phase: sources change only without a mask write
        m_mask = '0; m_ins = '0;
        wr(3'd1, 32'h0);
        for (int it = 0; it < 300; it++) begin
            logic [NSRC-1:0] s;
            logic [NSRC-1:0] m;
            int ev;
            s = NSRC'($urandom) & NSRC'($urandom) & NSRC'($urandom);
            m = NSRC'($urandom);
            set_src(s);
            wr(3'd1, {1'b0, m});
            m_mask = m;
            chk("R2 random irq", {31'b0, irq}, {31'b0, |(s & m_mask & ~m_ins)});
            ev = best(s & m_mask & ~m_ins);
            ack_chk("R5 random vector", ev);
            if (ev != 0) m_ins[ev-1] = 1'b1;
            rd(3'd2, d); chk("R6 random insvc", d, {1'b0, m_ins});
            if (($urandom % 4) == 0) begin
                logic [NSRC-1:0] c;
                c = NSRC'($urandom);
                wr(3'd2, {1'b0, c});
                m_ins = m_ins & ~c;
                rd(3'd2, d); chk("R7 random w1c", d, {1'b0, m_ins});
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule